// File: doc/BRIEF.md
# Microprocessor Parallel Slave Port

This block lets an external 8-bit microprocessor read and write a byte of a local controller's data at any time, with no relation to the local clock. The external master uses a bidirectional data bus and three active-low strobes: chip select, read and write. The local side sees a small register interface with one-cycle read latency. It has a data register, a direction register and a control/status register, plus an interrupt output.

There are two independent data latches behind the single local data address. A local write loads the outbound latch, which the external master reads. A local read returns the inbound latch, which the external master wrote. The control register holds the mode enable bit. When the bit is set, the direction register is ignored and the external master owns the bus direction. When the bit is clear, the data pins are ordinary general-purpose I/O.

All strobes and the data bus pass through a synchronizer chain before edge detection. An access counts on the rising (completing) edge of its read or write strobe. Each completed access updates the buffer-full flags and sets the interrupt flag.

Top module: `mpu_slave_port`

## Requirements
- R1: After synchronous reset, all registers and flags are zero. This means mode off, direction all inputs (pin_oe = 0), irq low, and a read of the control register returns 0x00.
- R2: Register map: address 0 is data, address 1 is direction, address 2 is control. With mode off, pin_oe equals the direction register (1 = drive) and pin_out equals the data latch. A data read returns pin_in as sampled two clocks before the read cycle.
- R3: With mode on, the direction register has no effect. pin_oe is all ones exactly while ext_cs_n and ext_rd_n are both low, and zero otherwise. pin_out carries the outbound latch.
- R4: With mode on, a rising edge of ext_wr_n completes an external write. At that edge, ext_cs_n must be low in the synchronised sample taken just before the edge or in the sample taken at the edge. The write captures the bus value present while ext_wr_n was low into the inbound latch. It also sets the input-full flag (control bit 1) on the third clock edge after ext_wr_n rises.
- R5: With mode on, a local read of address 0 returns the inbound latch and clears input-full. If an external write completes on the same edge, input-full stays set.
- R6: With mode on, a local write to address 0 sets the output-full flag (control bit 2). A completed external read (rising ext_rd_n with select as in R4) clears it. If both happen on the same edge, the local write wins.
- R7: Every completed external read or write in mode sets the interrupt flag (control bit 4), which drives irq. Writing 1 to control bit 4 clears it, and a new access on the same edge wins.
- R8: An external write that completes while input-full is already set sets the overflow flag (control bit 3), and the new byte replaces the inbound latch. Overflow stays set until a control write with bit 3 set.
- R9: With mode off, strobe activity changes no flag and does not set irq.
- R10: Strobes with ext_cs_n held high are ignored: no flag changes and no bus drive.
- R11: Control bit 0 is the read/write mode enable. loc_rdata updates on the clock edge that samples loc_rd and otherwise holds its value. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | 2 | Local register address |
| loc_wr | input | 1 | Local write strobe, one cycle |
| loc_rd | input | 1 | Local read strobe, one cycle |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Registered local read data |
| irq | output | 1 | Interrupt flag to local side |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| pin_in | input | 8 | Data pin input values |
| pin_out | output | 8 | Data pin output values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The checker watches, on every cycle, the bus-drive rule under mode, the rule that a completed access sets the interrupt and the matching buffer flag, and the rule that overflow only rises on top of a full input buffer. It also checks that strobes do nothing while the mode is off. What the assertions cannot show are data values and priorities. These are the byte that reaches the inbound latch, the two-cycle sampling of pins in general-purpose mode, and the same-edge contests between local and external accesses. The bench's reference model and its offset sweeps cover these.

// File: rtl/psp_pkg.sv
package psp_pkg;
  // local register addresses
  localparam int ADDR_DATA = 0;
  localparam int ADDR_DIR  = 1;
  localparam int ADDR_CTRL = 2;

  // control/status bit positions
  localparam int BIT_MODE = 0;
  localparam int BIT_IBF  = 1;
  localparam int BIT_OBF  = 2;
  localparam int BIT_OVF  = 3;
  localparam int BIT_IRQ  = 4;

  // positions inside the synchronised strobe vector
  localparam int STB_WR = 0;
  localparam int STB_RD = 1;
  localparam int STB_CS = 2;
  localparam int STB_W  = 3;

  typedef struct packed {
    logic irq;
    logic ovf;
    logic obf;
    logic ibf;
    logic mode;
  } psp_flags_t;
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_cur,
  output logic [W-1:0] q_prev
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  // the two oldest stages feed edge detection
  assign q_cur  = chain[STAGES-2];
  assign q_prev = chain[STAGES-1];
endmodule

// File: rtl/psp_access_det.sv
module psp_access_det
  import psp_pkg::*;
(
  input  logic             mode_en,
  input  logic [STB_W-1:0] stb_cur,
  input  logic [STB_W-1:0] stb_prev,
  output logic             wr_done,
  output logic             rd_done
);
  logic selected;

  // select counts if it was low around the completing edge
  assign selected = ~stb_prev[STB_CS] | ~stb_cur[STB_CS];

  assign wr_done = mode_en & selected & ~stb_prev[STB_WR] & stb_cur[STB_WR];
  assign rd_done = mode_en & selected & ~stb_prev[STB_RD] & stb_cur[STB_RD];
endmodule

// File: rtl/psp_regs.sv
module psp_regs
  import psp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] loc_addr,
  input  logic          loc_wr,
  input  logic          loc_rd,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          wr_done,
  input  logic          rd_done,
  input  logic [DW-1:0] cap_data,
  input  logic [DW-1:0] pin_sample,
  output logic [DW-1:0] port_lat,
  output logic [DW-1:0] dir_q,
  output psp_flags_t    flags
);
  logic [DW-1:0] in_lat;
  logic [DW-1:0] rd_val;
  logic          hit_data_wr, hit_data_rd, hit_ctrl_wr, hit_dir_wr;

  assign hit_data_wr = loc_wr && (loc_addr == AW'(ADDR_DATA));
  assign hit_dir_wr  = loc_wr && (loc_addr == AW'(ADDR_DIR));
  assign hit_ctrl_wr = loc_wr && (loc_addr == AW'(ADDR_CTRL));
  assign hit_data_rd = loc_rd && (loc_addr == AW'(ADDR_DATA));

  always_comb begin
    rd_val = '0;
    case (loc_addr)
      AW'(ADDR_DATA): rd_val = flags.mode ? in_lat : pin_sample;
      AW'(ADDR_DIR):  rd_val = dir_q;
      AW'(ADDR_CTRL): begin
        rd_val[BIT_MODE] = flags.mode;
        rd_val[BIT_IBF]  = flags.ibf;
        rd_val[BIT_OBF]  = flags.obf;
        rd_val[BIT_OVF]  = flags.ovf;
        rd_val[BIT_IRQ]  = flags.irq;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_lat  <= '0;
      dir_q     <= '0;
      in_lat    <= '0;
      loc_rdata <= '0;
      flags     <= '0;
    end else begin
      if (hit_data_wr) port_lat <= loc_wdata;
      if (hit_dir_wr)  dir_q    <= loc_wdata;
      if (hit_ctrl_wr) flags.mode <= loc_wdata[BIT_MODE];
      if (loc_rd)      loc_rdata <= rd_val;

      if (wr_done) in_lat <= cap_data;

      // external write wins over the local read
      if (wr_done)                        flags.ibf <= 1'b1;
      else if (hit_data_rd && flags.mode) flags.ibf <= 1'b0;

      // local write wins over the external read
      if (hit_data_wr && flags.mode) flags.obf <= 1'b1;
      else if (rd_done)              flags.obf <= 1'b0;

      if (wr_done && flags.ibf)                    flags.ovf <= 1'b1;
      else if (hit_ctrl_wr && loc_wdata[BIT_OVF])  flags.ovf <= 1'b0;

      if (wr_done || rd_done)                      flags.irq <= 1'b1;
      else if (hit_ctrl_wr && loc_wdata[BIT_IRQ])  flags.irq <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_slave_port.sv
module mpu_slave_port
  import psp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] loc_addr,
  input  logic          loc_wr,
  input  logic          loc_rd,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  output logic          irq,
  input  logic          ext_cs_n,
  input  logic          ext_rd_n,
  input  logic          ext_wr_n,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe
);
  logic [STB_W-1:0] stb_raw, stb_cur, stb_prev;
  logic [DW-1:0]    pin_cur, pin_prev;
  logic [DW-1:0]    port_lat, dir_q;
  psp_flags_t       flags;
  logic             wr_done, rd_done;
  logic             mode_en, ibf, obf, ovf;

  always_comb begin
    stb_raw         = '0;
    stb_raw[STB_WR] = ext_wr_n;
    stb_raw[STB_RD] = ext_rd_n;
    stb_raw[STB_CS] = ext_cs_n;
  end

  psp_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
    .clk(clk), .rst(rst), .d(stb_raw), .q_cur(stb_cur), .q_prev(stb_prev)
  );

  psp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q_cur(pin_cur), .q_prev(pin_prev)
  );

  psp_access_det u_det (
    .mode_en(mode_en), .stb_cur(stb_cur), .stb_prev(stb_prev),
    .wr_done(wr_done), .rd_done(rd_done)
  );

  psp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .wr_done(wr_done), .rd_done(rd_done),
    .cap_data(pin_prev), .pin_sample(pin_cur),
    .port_lat(port_lat), .dir_q(dir_q), .flags(flags)
  );

  assign mode_en = flags.mode;
  assign ibf     = flags.ibf;
  assign obf     = flags.obf;
  assign ovf     = flags.ovf;
  assign irq     = flags.irq;

  // bus drive follows the raw strobes so the master sees data without clock delay
  assign pin_oe  = mode_en ? {DW{~ext_cs_n & ~ext_rd_n}} : dir_q;
  assign pin_out = port_lat;
endmodule

// File: rtl/mpu_slave_port_chk.sv
module mpu_slave_port_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_cs_n,
  input logic          ext_rd_n,
  input logic [DW-1:0] pin_oe,
  input logic [AW-1:0] loc_addr,
  input logic          loc_wr,
  input logic          mode_en,
  input logic          ibf,
  input logic          obf,
  input logic          ovf,
  input logic          irq,
  input logic          wr_done,
  input logic          rd_done
);
  // R3: master read in mode drives every pin
  a_r3_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (mode_en && !ext_cs_n && !ext_rd_n) |-> (pin_oe == {DW{1'b1}}));

  // R3: no drive in mode without a selected read
  a_r3_float_otherwise: assert property (@(posedge clk) disable iff (rst)
    (mode_en && (ext_cs_n || ext_rd_n)) |-> (pin_oe == '0));

  // R4: completed write fills the input buffer
  a_r4_write_sets_ibf: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> ibf);

  // R6: local data write in mode fills the output buffer
  a_r6_local_write_obf: assert property (@(posedge clk) disable iff (rst)
    (mode_en && loc_wr && loc_addr == '0) |=> obf);

  // R7: any completed access raises the interrupt
  a_r7_access_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_done || rd_done) |=> irq);

  // R8: overflow only rises on top of a full input buffer
  a_r8_ovf_needs_ibf: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(ibf));

  // R9: no access is recognised with mode off
  a_r9_idle_in_gpio: assert property (@(posedge clk) disable iff (rst)
    !mode_en |-> (!wr_done && !rd_done));
endmodule

bind mpu_slave_port mpu_slave_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
  .pin_oe(pin_oe), .loc_addr(loc_addr), .loc_wr(loc_wr),
  .mode_en(mode_en), .ibf(ibf), .obf(obf), .ovf(ovf), .irq(irq),
  .wr_done(wr_done), .rd_done(rd_done)
);

// File: tb/tb_mpu_slave_port.sv
module tb_mpu_slave_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] loc_addr = '0;
  logic       loc_wr = 1'b0, loc_rd = 1'b0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  logic       irq;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  mpu_slave_port dut (
    .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .irq(irq),
    .ext_cs_n(cs_n), .ext_rd_n(rd_n), .ext_wr_n(wr_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_dir, m_lat, m_in, m_rdata;
  bit         m_mode, m_ibf, m_obf, m_ovf, m_irq;
  logic [7:0] hd[$];
  bit         hw[$], hr[$], hc[$];
  bit         e_wr, e_rd, e_sel;
  logic [7:0] e_cap;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 0; m_lat = 0; m_in = 0; m_rdata = 0;
      m_mode = 0; m_ibf = 0; m_obf = 0; m_ovf = 0; m_irq = 0;
      hd = '{8'h0, 8'h0, 8'h0};
      hw = '{1, 1, 1}; hr = '{1, 1, 1}; hc = '{1, 1, 1};
    end else begin
      // index 0 is the previous edge's sample, 2 is three edges back
      e_sel = !hc[2] || !hc[1];
      e_wr  = m_mode && e_sel && hw[1] && !hw[2];
      e_rd  = m_mode && e_sel && hr[1] && !hr[2];
      e_cap = hd[2];
      if (loc_rd) begin
        case (loc_addr)
          2'd0: m_rdata = m_mode ? m_in : hd[1];
          2'd1: m_rdata = m_dir;
          2'd2: m_rdata = {3'b0, m_irq, m_ovf, m_obf, m_ibf, m_mode};
          default: m_rdata = 8'h0;
        endcase
      end
      if (e_wr && m_ibf) m_ovf = 1;
      else if (loc_wr && loc_addr == 2 && loc_wdata[3]) m_ovf = 0;
      if (e_wr) m_ibf = 1;
      else if (loc_rd && loc_addr == 0 && m_mode) m_ibf = 0;
      if (loc_wr && loc_addr == 0 && m_mode) m_obf = 1;
      else if (e_rd) m_obf = 0;
      if (e_wr || e_rd) m_irq = 1;
      else if (loc_wr && loc_addr == 2 && loc_wdata[4]) m_irq = 0;
      if (e_wr) m_in = e_cap;
      if (loc_wr && loc_addr == 0) m_lat = loc_wdata;
      if (loc_wr && loc_addr == 1) m_dir = loc_wdata;
      if (loc_wr && loc_addr == 2) m_mode = loc_wdata[0];
      hd.push_front(pin_in); void'(hd.pop_back());
      hw.push_front(wr_n);   void'(hw.pop_back());
      hr.push_front(rd_n);   void'(hr.pop_back());
      hc.push_front(cs_n);   void'(hc.pop_back());
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq vs model", irq, m_irq);
      if (m_mode) chk("R3 pin_oe vs model", pin_oe, (!cs_n && !rd_n) ? 8'hFF : 8'h00);
      else        chk("R2 pin_oe vs model", pin_oe, m_dir);
      chk("R2 pin_out vs model", pin_out, m_lat);
      chk("R11 loc_rdata vs model", loc_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loc_write(input logic [1:0] a, input logic [7:0] d);
    loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
    step();
    loc_wr = 1'b0;
  endtask

  task automatic loc_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    loc_addr = a; loc_rd = 1'b1;
    step();
    loc_rd = 1'b0;
    @(negedge clk);
    chk(tag, loc_rdata, exp);
    step();
  endtask

  task automatic ext_write(input logic [7:0] d, input logic csv);
    cs_n = csv; pin_in = d; wr_n = 1'b0;
    step(3);
    wr_n = 1'b1;
    step(1);
    cs_n = 1'b1;
    step(4);
  endtask

  task automatic ext_read(input logic csv, input logic [7:0] exp_oe,
                          input logic [7:0] exp_out, input string tag);
    cs_n = csv; rd_n = 1'b0;
    step(2);
    @(negedge clk);
    chk(tag, pin_oe, exp_oe);
    chk(tag, pin_out, exp_out);
    step();
    rd_n = 1'b1;
    step(1);
    cs_n = 1'b1;
    step(4);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 pin_oe after reset", pin_oe, 8'h00);
    step();
    loc_read(2, 8'h00, "R1 ctrl after reset");
    loc_read(1, 8'h00, "R1 dir after reset");
    loc_read(3, 8'h00, "R11 unused address");

    // R2: general-purpose I/O
    loc_write(1, 8'hA5);
    loc_write(0, 8'h3C);
    @(negedge clk);
    chk("R2 gpio oe", pin_oe, 8'hA5);
    chk("R2 gpio out", pin_out, 8'h3C);
    step();
    pin_in = 8'h5A;
    step(3);
    loc_read(0, 8'h5A, "R2 gpio pin read");

    // R9: strobes ignored with mode off
    ext_write(8'h99, 1'b0);
    ext_read(1'b0, 8'hA5, 8'h3C, "R9 gpio read strobe");
    loc_read(2, 8'h00, "R9 no flags in gpio");

    // R3, R11: enable mode, direction ignored
    loc_write(2, 8'h01);
    @(negedge clk);
    chk("R3 dir ignored", pin_oe, 8'h00);
    step();
    loc_read(2, 8'h01, "R11 mode bit");

    // R6, R7: outbound path
    loc_write(0, 8'h77);
    loc_read(2, 8'h05, "R6 obf set");
    ext_read(1'b0, 8'hFF, 8'h77, "R3 read drive");
    loc_read(2, 8'h11, "R6 obf cleared, R7 irq set");
    chk("R7 irq pin", irq, 1);
    loc_write(2, 8'h11);
    loc_read(2, 8'h01, "R7 irq cleared");

    // R4, R5: inbound path
    ext_write(8'h42, 1'b0);
    loc_read(2, 8'h13, "R4 ibf set");
    loc_read(0, 8'h42, "R4 inbound data");
    loc_read(2, 8'h11, "R5 ibf cleared");
    loc_write(2, 8'h11);

    // R8: overflow
    ext_write(8'h10, 1'b0);
    ext_write(8'h20, 1'b0);
    loc_read(2, 8'h1B, "R8 ovf set");
    loc_read(0, 8'h20, "R8 newest byte kept");
    loc_read(2, 8'h19, "R8 ovf sticky");
    loc_write(2, 8'h09);
    loc_read(2, 8'h11, "R8 ovf cleared");
    loc_write(2, 8'h11);

    // R10: unselected strobes
    loc_write(0, 8'h66);
    ext_write(8'h55, 1'b1);
    ext_read(1'b1, 8'h00, 8'h66, "R10 no drive unselected");
    loc_read(2, 8'h05, "R10 flags unchanged");
    chk("R10 irq stays low", irq, 0);

    // R6: local write against external read completion, edge offsets swept
    for (int off = 0; off < 5; off++) begin
      loc_write(2, 8'h19);
      loc_write(0, 8'h80 + off[7:0]);
      cs_n = 1'b0; rd_n = 1'b0;
      step(2);
      rd_n = 1'b1;
      step(off);
      loc_write(0, 8'hC0);
      step(5);
      cs_n = 1'b1;
      step(2);
      loc_read(2, (off >= 2) ? 8'h15 : 8'h11, "R6 same-edge priority");
    end

    // R5: local read against external write completion, edge offsets swept
    loc_write(2, 8'h19);
    for (int off = 0; off < 5; off++) begin
      loc_write(2, 8'h19);
      loc_addr = 0; loc_rd = 1'b1; step(); loc_rd = 1'b0;
      cs_n = 1'b0; pin_in = 8'h30 + off[7:0]; wr_n = 1'b0;
      step(2);
      wr_n = 1'b1;
      step(off);
      loc_addr = 0; loc_rd = 1'b1; step(); loc_rd = 1'b0;
      step(5);
      cs_n = 1'b1;
      step(2);
      loc_read(2, ((off <= 2) ? 8'h13 : 8'h11) | ((m_obf) ? 8'h04 : 8'h00), "R5 same-edge priority");
    end

    step(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule